// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns the operand fields of a load, store or PC-relative address instruction into the byte address that the memory pipeline will use. It also produces the updated base value for writeback forms. One request may be accepted on every clock. The unit forms an offset from an immediate, from an index register that is extended and scaled, or from a paired-access immediate. It adds that offset to a base or to the program counter. The result is registered, so it appears one cycle after the request.

The unit also guards the stack pointer. At the least privileged level, a stack-pointer base that is not 16-byte aligned raises a fault flag, and writeback is then cancelled. All sums wrap modulo 2^64. The memory access itself happens elsewhere.

Top module: `agu_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is zero.
- R2: A request presented with `req_valid` high in cycle N shows its results in cycle N+1 with `out_valid` high. A cycle with `req_valid` low gives all-zero outputs in the following cycle.
- R3: Mode 0 (scaled unsigned): the address is base + `imm[11:0]` × 2^`size_log2` (size_log2 is 0..4 for 1..16 bytes). There is no writeback.
- R4: Mode 1 (unscaled): the address is base + the sign-extended `imm[8:0]` (byte units, −256..+255). There is no writeback.
- R5: Mode 2 (register): the index is taken as the full 64 bits for `ext_sel` 0 or 3, as `index[31:0]` zero-extended for `ext_sel` 1, and as `index[31:0]` sign-extended for `ext_sel` 2. When `shift_en` is 1 it is then multiplied by 2^`size_log2`. The address is base + index. There is no writeback.
- R6: Mode 3 (pre-index): the address and the writeback value are both base + the immediate offset of R4 or R8, and `wb_en` is 1.
- R7: Mode 4 (post-index): the address is the unmodified base, the writeback value is base + the immediate offset of R4 or R8, and `wb_en` is 1.
- R8: With `pair` set in modes 0, 1, 3 and 4, the immediate offset is the sign-extended `imm[6:0]` × 2^`size_log2`. In every mode except 5 and 6, a set `pair` gives `pair_addr` = address + 2^`size_log2`. Otherwise `pair_addr` is zero.
- R9: Mode 5 (near PC-relative): the address is pc + the sign-extended `imm[20:0]`. There is no writeback and no fault.
- R10: Mode 6 (page PC-relative): the address is pc with bits 11:0 cleared, plus the sign-extended `imm[20:0]` × 4096. There is no writeback and no fault.
- R11: In any mode other than 5 and 6, `align_fault` is 1 exactly when `base_is_sp` is 1, `priv_level` is 0 and `base[3:0]` is nonzero. A fault forces `wb_en` to 0.
- R12: All address and writeback sums wrap modulo 2^64.
- R13: Mode 7 (reserved): the address is the base with no offset, and there is no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code (0..7) |
| ext_sel | input | 2 | Index extend selector for mode 2 |
| shift_en | input | 1 | Scale the index by the access size |
| size_log2 | input | 3 | log2 of the access size in bytes, 0..4 |
| pair | input | 1 | Paired access |
| imm | input | 21 | Raw immediate field |
| base | input | 64 | Base register value |
| index | input | 64 | Index register value |
| pc | input | 64 | Program counter of the instruction |
| base_is_sp | input | 1 | Base register is the stack pointer |
| priv_level | input | 2 | Current privilege level |
| out_valid | output | 1 | Results valid |
| eff_addr | output | 64 | Effective address |
| pair_addr | output | 64 | Address of the second pair element |
| wb_en | output | 1 | Base writeback enable |
| wb_value | output | 64 | Value to write to the base |
| align_fault | output | 1 | Stack-pointer alignment fault |

## Verification
Every output is one register away from the inputs, so each result is due on the clock edge after its request. The bench drives a request a short time after a rising edge and waits for the next edge. It then waits a further two nanoseconds before it compares all six outputs with a reference computed from the values it drove. Idle cycles are checked the same way and must give zeros one edge later. The reference uses multiplication and signed integer arithmetic rather than shifts and slices.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
    typedef enum logic [2:0] {
        AM_UIMM   = 3'd0,
        AM_SIMM   = 3'd1,
        AM_REG    = 3'd2,
        AM_PRE    = 3'd3,
        AM_POST   = 3'd4,
        AM_PCNEAR = 3'd5,
        AM_PCPAGE = 3'd6,
        AM_RSVD   = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        EX_LSL  = 2'd0,
        EX_UXTW = 2'd1,
        EX_SXTW = 2'd2,
        EX_SXTX = 2'd3
    } ext_e;

    function automatic logic is_pc_mode(input amode_e m);
        return (m == AM_PCNEAR) || (m == AM_PCPAGE);
    endfunction

    function automatic logic is_imm_mode(input amode_e m);
        return (m == AM_UIMM) || (m == AM_SIMM) || (m == AM_PRE) || (m == AM_POST);
    endfunction
endpackage

// File: rtl/agu_offset.sv
`timescale 1ns/1ps
// Offset former: immediate or extended/scaled index, chosen by mode.
module agu_offset
    import agu_pkg::*;
#(
    parameter int AW    = 64,
    parameter int IMMW  = 21,
    parameter int UIMMW = 12,
    parameter int SIMMW = 9,
    parameter int PIMMW = 7,
    parameter int SZW   = 3
) (
    input  amode_e          mode,
    input  ext_e            ext_sel,
    input  logic            shift_en,
    input  logic [SZW-1:0]  size_log2,
    input  logic            pair,
    input  logic [IMMW-1:0] imm,
    input  logic [AW-1:0]   index,
    output logic [AW-1:0]   offset
);
    localparam int HALF = 32;

    logic [AW-1:0] uimm_x, simm_x, pimm_x, idx_x;

    always_comb begin
        uimm_x = {{(AW-UIMMW){1'b0}}, imm[UIMMW-1:0]};
        simm_x = {{(AW-SIMMW){imm[SIMMW-1]}}, imm[SIMMW-1:0]};
        pimm_x = {{(AW-PIMMW){imm[PIMMW-1]}}, imm[PIMMW-1:0]};
        unique case (ext_sel)
            EX_UXTW: idx_x = {{(AW-HALF){1'b0}}, index[HALF-1:0]};
            EX_SXTW: idx_x = {{(AW-HALF){index[HALF-1]}}, index[HALF-1:0]};
            default: idx_x = index;
        endcase

        if (pair && is_imm_mode(mode)) begin
            offset = pimm_x << size_log2;
        end else begin
            unique case (mode)
                AM_UIMM: offset = uimm_x << size_log2;
                AM_SIMM, AM_PRE, AM_POST: offset = simm_x;
                AM_REG:  offset = shift_en ? (idx_x << size_log2) : idx_x;
                default: offset = '0;
            endcase
        end
    end
endmodule

// File: rtl/agu_sp_check.sv
`timescale 1ns/1ps
// Stack-pointer alignment guard at the least privileged level.
module agu_sp_check
    import agu_pkg::*;
#(
    parameter int ALIGN_BITS = 4,
    parameter int PLW        = 2
) (
    input  amode_e                mode,
    input  logic                  base_is_sp,
    input  logic [PLW-1:0]        priv_level,
    input  logic [ALIGN_BITS-1:0] base_lo,
    output logic                  fault
);
    always_comb begin
        fault = base_is_sp && (priv_level == '0) && (base_lo != '0) && !is_pc_mode(mode);
    end
endmodule

// File: rtl/agu_top.sv
`timescale 1ns/1ps
module agu_top
    import agu_pkg::*;
#(
    parameter int AW      = 64,
    parameter int IMMW    = 21,
    parameter int SZW     = 3,
    parameter int PLW     = 2,
    parameter int PAGE_SH = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      mode,
    input  logic [1:0]      ext_sel,
    input  logic            shift_en,
    input  logic [SZW-1:0]  size_log2,
    input  logic            pair,
    input  logic [IMMW-1:0] imm,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   index,
    input  logic [AW-1:0]   pc,
    input  logic            base_is_sp,
    input  logic [PLW-1:0]  priv_level,
    output logic            out_valid,
    output logic [AW-1:0]   eff_addr,
    output logic [AW-1:0]   pair_addr,
    output logic            wb_en,
    output logic [AW-1:0]   wb_value,
    output logic            align_fault
);
    localparam int ALIGN_BITS = 4;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] ea;
        logic [AW-1:0] ea2;
        logic          wbe;
        logic [AW-1:0] wbv;
        logic          flt;
    } res_t;

    res_t    res_d, res_q;
    amode_e  m;
    ext_e    ex;
    logic [AW-1:0] off, sum, pc_simm, step;
    logic    sp_flt, wants_wb;

    assign m  = amode_e'(mode);
    assign ex = ext_e'(ext_sel);

    agu_offset #(.AW(AW), .IMMW(IMMW), .SZW(SZW)) u_off (
        .mode(m), .ext_sel(ex), .shift_en(shift_en), .size_log2(size_log2),
        .pair(pair), .imm(imm), .index(index), .offset(off)
    );

    agu_sp_check #(.ALIGN_BITS(ALIGN_BITS), .PLW(PLW)) u_sp (
        .mode(m), .base_is_sp(base_is_sp), .priv_level(priv_level),
        .base_lo(base[ALIGN_BITS-1:0]), .fault(sp_flt)
    );

    always_comb begin
        res_d    = '0;
        sum      = base + off;
        pc_simm  = {{(AW-IMMW){imm[IMMW-1]}}, imm};
        step     = {{(AW-1){1'b0}}, 1'b1} << size_log2;
        wants_wb = 1'b0;
        if (req_valid) begin
            res_d.vld = 1'b1;
            unique case (m)
                AM_PRE:    begin res_d.ea = sum;  res_d.wbv = sum; wants_wb = 1'b1; end
                AM_POST:   begin res_d.ea = base; res_d.wbv = sum; wants_wb = 1'b1; end
                AM_PCNEAR: res_d.ea = pc + pc_simm;
                AM_PCPAGE: res_d.ea = {pc[AW-1:PAGE_SH], {PAGE_SH{1'b0}}} + (pc_simm << PAGE_SH);
                AM_RSVD:   res_d.ea = base;
                default:   res_d.ea = sum;
            endcase
            if (pair && !is_pc_mode(m)) res_d.ea2 = res_d.ea + step;
            res_d.flt = sp_flt;
            res_d.wbe = wants_wb && !sp_flt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.vld;
    assign eff_addr    = res_q.ea;
    assign pair_addr   = res_q.ea2;
    assign wb_en       = res_q.wbe;
    assign wb_value    = res_q.wbv;
    assign align_fault = res_q.flt;
endmodule

// File: rtl/agu_top_chk.sv
`timescale 1ns/1ps
module agu_top_chk #(
    parameter int AW   = 64,
    parameter int IMMW = 21,
    parameter int SZW  = 3,
    parameter int PLW  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      mode,
    input logic [1:0]      ext_sel,
    input logic            shift_en,
    input logic [SZW-1:0]  size_log2,
    input logic            pair,
    input logic [IMMW-1:0] imm,
    input logic [AW-1:0]   base,
    input logic [AW-1:0]   index,
    input logic [AW-1:0]   pc,
    input logic            base_is_sp,
    input logic [PLW-1:0]  priv_level,
    input logic            out_valid,
    input logic [AW-1:0]   eff_addr,
    input logic [AW-1:0]   pair_addr,
    input logic            wb_en,
    input logic [AW-1:0]   wb_value,
    input logic            align_fault
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wb_en && !align_fault && eff_addr == '0)); // R2
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_FAULT_BLOCKS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> !wb_en); // R11
    AST_PRE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd3) |=> (eff_addr == wb_value)); // R6
    AST_POST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd4) |=> (eff_addr == $past(base))); // R7
    AST_PC_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (mode == 3'd5 || mode == 3'd6)) |=> (!wb_en && !align_fault)); // R9
    AST_PAGE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd6) |=> (eff_addr[11:0] == 12'd0)); // R10
    AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pair && mode != 3'd5 && mode != 3'd6)
        |=> (pair_addr - eff_addr == ({{(AW-1){1'b0}}, 1'b1} << $past(size_log2)))); // R8
    AST_NOWB_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (mode <= 3'd2 || mode == 3'd7)) |=> !wb_en); // R3
endmodule

bind agu_top agu_top_chk #(.AW(AW), .IMMW(IMMW), .SZW(SZW), .PLW(PLW)) u_chk (.*);

// File: tb/agu_top_bench.sv
`timescale 1ns/1ps
module agu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ext_sel = '0;
    logic        shift_en = 1'b0;
    logic [2:0]  size_log2 = '0;
    logic        pair = 1'b0;
    logic [20:0] imm = '0;
    logic [63:0] base = '0, index = '0, pc = '0;
    logic        base_is_sp = 1'b0;
    logic [1:0]  priv_level = '0;
    logic        out_valid, wb_en, align_fault;
    logic [63:0] eff_addr, pair_addr, wb_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    agu_top u_agu_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .ext_sel(ext_sel),
        .shift_en(shift_en), .size_log2(size_log2), .pair(pair), .imm(imm), .base(base),
        .index(index), .pc(pc), .base_is_sp(base_is_sp), .priv_level(priv_level),
        .out_valid(out_valid), .eff_addr(eff_addr), .pair_addr(pair_addr), .wb_en(wb_en),
        .wb_value(wb_value), .align_fault(align_fault)
    );

    // expected results
    logic        e_vld, e_wbe, e_flt;
    logic [63:0] e_ea, e_ea2, e_wbv;

    function automatic longint sgn(input logic [63:0] v, input int bits);
        longint r;
        r = longint'(v) & ((longint'(1) << bits) - 1);
        if (v[bits-1]) r = r - (longint'(1) << bits);
        return r;
    endfunction

    task automatic model();
        longint sz, ioff, roff;
        e_vld = req_valid; e_ea = 0; e_ea2 = 0; e_wbe = 0; e_wbv = 0; e_flt = 0;
        if (!req_valid) return;
        sz = longint'(1) << size_log2;
        if (pair) ioff = sgn(64'(imm), 7) * sz;
        else if (mode == 0) ioff = longint'(imm & 21'hFFF) * sz;
        else ioff = sgn(64'(imm), 9);
        case (ext_sel)
            2'd1: roff = longint'(index & 64'hFFFF_FFFF);
            2'd2: roff = sgn(index, 32);
            default: roff = longint'(index);
        endcase
        if (shift_en) roff = roff * sz;
        case (mode)
            3'd0, 3'd1: e_ea = base + 64'(ioff);
            3'd2: e_ea = base + 64'(roff);
            3'd3: begin e_ea = base + 64'(ioff); e_wbv = e_ea; e_wbe = 1; end
            3'd4: begin e_ea = base; e_wbv = base + 64'(ioff); e_wbe = 1; end
            3'd5: e_ea = pc + 64'(sgn(64'(imm), 21));
            3'd6: e_ea = (pc / 4096) * 4096 + 64'(sgn(64'(imm), 21) * 4096);
            default: e_ea = base;
        endcase
        if (mode != 5 && mode != 6) begin
            e_flt = base_is_sp && priv_level == 0 && (base % 16) != 0;
            if (pair) e_ea2 = e_ea + 64'(sz);
        end
        if (e_flt) e_wbe = 0;
    endtask

    task automatic cmp1(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        cmp1(tag, "out_valid", 64'(out_valid), 64'(e_vld));
        cmp1(tag, "eff_addr", eff_addr, e_ea);
        cmp1(tag, "pair_addr", pair_addr, e_ea2);
        cmp1(tag, "wb_en", 64'(wb_en), 64'(e_wbe));
        cmp1(tag, "wb_value", wb_value, e_wbv);
        cmp1(tag, "align_fault", 64'(align_fault), 64'(e_flt));
    endtask

    // drive one cycle, result is due one edge later
    task automatic apply(input string tag, input logic v, input logic [2:0] md, input logic [1:0] ex,
                         input logic sh, input logic [2:0] sz, input logic pr, input logic [20:0] im,
                         input logic [63:0] b, input logic [63:0] ix, input logic [63:0] p,
                         input logic sp, input logic [1:0] pl);
        req_valid = v; mode = md; ext_sel = ex; shift_en = sh; size_log2 = sz; pair = pr;
        imm = im; base = b; index = ix; pc = p; base_is_sp = sp; priv_level = pl;
        model();
        @(posedge clk); #2;
        compare_all(tag);
    endtask

    function automatic string tag_of(input logic [2:0] md, input logic pr);
        if (pr && md != 5 && md != 6) return "R8";
        case (md)
            3'd0: return "R3"; 3'd1: return "R4"; 3'd2: return "R5";
            3'd3: return "R6"; 3'd4: return "R7"; 3'd5: return "R9";
            3'd6: return "R10"; default: return "R13";
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        e_vld = 0; e_ea = 0; e_ea2 = 0; e_wbe = 0; e_wbv = 0; e_flt = 0;
        compare_all("R1");
        rst_n = 1'b1;
        @(posedge clk); #2;
        compare_all("R1");

        // R3 scaled: 4095 * 8
        apply("R3", 1, 0, 0, 0, 3, 0, 21'h0FFF, 64'h1000, 0, 0, 0, 0);
        // R4 unscaled, negative and positive extreme
        apply("R4", 1, 1, 0, 0, 3, 0, 21'h100, 64'h2000, 0, 0, 0, 0);
        apply("R4", 1, 1, 0, 0, 2, 0, 21'h0FF, 64'h2000, 0, 0, 0, 0);
        // R5 register forms
        apply("R5", 1, 2, 0, 1, 3, 0, 0, 64'h4000, 64'h5, 0, 0, 0);
        apply("R5", 1, 2, 1, 1, 2, 0, 0, 64'h4000, 64'hFFFF_FFFF_8000_0001, 0, 0, 0);
        apply("R5", 1, 2, 2, 0, 2, 0, 0, 64'h4000, 64'h0000_0000_FFFF_FFFF, 0, 0, 0);
        apply("R5", 1, 2, 3, 1, 3, 0, 0, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 0);
        // R6 pre-index / R7 post-index
        apply("R6", 1, 3, 0, 0, 3, 0, 21'h1F0, 64'h8000, 0, 0, 1, 0);
        apply("R7", 1, 4, 0, 0, 3, 0, 21'h008, 64'h8000, 0, 0, 0, 0);
        // R8 pair pre-index with -32*8 and plain pair
        apply("R8", 1, 3, 0, 0, 3, 1, 21'h60, 64'h9000, 0, 0, 1, 0);
        apply("R8", 1, 0, 0, 0, 4, 1, 21'h3F, 64'h9000, 0, 0, 0, 0);
        // R9 near PC, R10 page
        apply("R9", 1, 5, 0, 0, 0, 0, 21'h100000, 64'h0010_0000, 0, 0, 1, 0);
        apply("R10", 1, 6, 0, 0, 0, 1, 21'h1FFFFF, 64'h1234_5ABC, 0, 0, 1, 0);
        // R11 faults and non-faults
        apply("R11", 1, 3, 0, 0, 3, 0, 21'h010, 64'h8008, 0, 0, 1, 0);
        apply("R11", 1, 3, 0, 0, 3, 0, 21'h010, 64'h8008, 0, 0, 1, 1);
        apply("R11", 1, 4, 0, 0, 3, 0, 21'h010, 64'h8010, 0, 0, 1, 0);
        apply("R11", 1, 4, 0, 0, 3, 0, 21'h010, 64'h8004, 0, 0, 0, 0);
        // R12 wrap
        apply("R12", 1, 1, 0, 0, 0, 0, 21'h0FF, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 0, 0);
        apply("R12", 1, 5, 0, 0, 0, 0, 21'h1FFFFF, 64'h0, 0, 0, 0, 0);
        // R13 reserved
        apply("R13", 1, 7, 0, 0, 3, 0, 21'h0FFF, 64'hABC0, 0, 0, 0, 0);
        // R2 idle after a request, then back-to-back
        apply("R2", 0, 3, 0, 0, 3, 0, 21'h010, 64'h8000, 0, 0, 0, 0);
        apply("R2", 1, 3, 0, 0, 3, 0, 21'h010, 64'h8000, 0, 0, 0, 0);

        for (int i = 0; i < 400; i++) begin
            logic [2:0] md; logic pr; logic [63:0] b;
            md = 3'($urandom_range(0, 7));
            pr = 1'($urandom);
            b  = {32'($urandom), 32'($urandom)};
            if ($urandom_range(0, 1) == 0) b[3:0] = 4'd0;
            apply((i % 9 == 0) ? "R2" : tag_of(md, pr), (i % 9 != 0), md, 2'($urandom), 1'($urandom),
                  3'($urandom_range(0, 4)), pr, 21'($urandom), b,
                  {32'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)},
                  1'($urandom), 2'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule